// File: doc/BRIEF.md
# I2C Master Byte-Transfer Sequencer

This block runs master-mode byte transfers over an abstract byte-level bus port. The block does not generate SCL timing. Software programs a transfer length and loads outgoing bytes into a four-entry holding buffer. It then writes a control word that enables the block, claims the master role and requests a start. The sequencer then issues start, send, receive and stop operations one at a time. Each operation is a request held until the bus side answers with a one-cycle done pulse and, for start and send, an acknowledge bit.

Normal mode runs off a running byte count that is loaded from the programmed length when the transfer starts. When that count reaches zero, the transfer ends by itself, with a stop only if the stop bit was set. Repeat mode never reads the count. It keeps moving bytes for as long as the buffer allows, and it ends only when software sets the stop bit. Sticky NACK and access-ready flags, together with live transmit-ready and receive-ready levels, tell software when to act.

The sequencer has six named states. IDLE waits for a start request. START waits for the start operation to complete. ACTIVE decides the next step. SEND and RECV each wait for one byte operation. STOP waits for the stop operation. The transitions are: IDLE to START on an accepted start request. START to ACTIVE on an acknowledged start, or START to STOP on a refused one. ACTIVE to SEND or RECV when a byte can move. ACTIVE to STOP when the end of a transfer needs a stop. ACTIVE to IDLE when a normal transfer ends without a stop. SEND to ACTIVE after an acknowledged byte, or SEND to STOP after a refused one. RECV to ACTIVE after each byte. STOP to IDLE when the stop completes. Any state goes to IDLE when the enable bit is written to 0.

Top module: `i2c_byte_sequencer`

## Requirements
- R1: A control write keeps only the bits in mask 0xCF87. The bit positions are enable 15, byte-order 14, master 10, transmit 9, ten-bit 8, repeat 2, stop 1 and start 0. After reset the control word, running count, buffer level and all flags read 0.
- R2: When the block is idle, a control write with enable, master and start all 1 issues one start operation (op code 0) to `slave_addr`. `bus_rd` is the inverse of the transmit bit. The start bit clears when that operation completes. A start write with master 0 issues no operation and clears the start bit.
- R3: The running count is loaded from the programmed count when a start is accepted. It is reloaded again when any stop operation completes.
- R4: In normal transmit, buffered bytes are sent (op code 1) in the order they were pushed, and each completed byte lowers the count by one. If the buffer is empty while the count is nonzero, the sequencer waits with `stat_xrdy` high.
- R5: When the count is zero in normal mode, a stop operation (op code 3) is issued if the stop bit is set, and that bit then clears. In either case ARDY is set, the master bit clears and the block goes idle.
- R6: In normal receive, bytes are fetched (op code 2) while the count is nonzero and the buffer holds fewer than 4 bytes. `stat_rrdy` is high whenever the transmit bit is 0 and the buffer is not empty.
- R7: A refused start or a refused send sets NACK and clears the stop bit. The block then issues a stop, clears master and goes idle without setting ARDY.
- R8: In repeat mode the count is neither tested nor lowered. Transmit sends while bytes remain and receive fetches while space remains. Setting the stop bit issues a stop, after which the stop and master bits clear and ARDY stays 0.
- R9: A control write with enable 0 aborts at once. It drops any bus request, returns the block to idle and clears the start and stop bits.
- R10: NACK and ARDY stay set until cleared through `stat_clr`, with bit 0 clearing NACK and bit 1 clearing ARDY.
- R11: The holding buffer is first-in first-out and holds 4 bytes. A push to a full buffer and a pop from an empty buffer are ignored, and `rx_byte` always shows the oldest byte.
- R12: Only one bus operation is outstanding at a time. `bus_req` and `bus_op` hold steady until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write value |
| ctrl_q | output | 16 | Current control word |
| cnt_we | input | 1 | Programmed count write strobe |
| cnt_wdata | input | CNT_W | Programmed transfer length |
| count_cur | output | CNT_W | Running byte count |
| slave_addr | input | 7 | Target address used by a start |
| tx_push | input | 1 | Push `tx_byte` into the holding buffer |
| tx_byte | input | 8 | Byte pushed by software |
| rx_pop | input | 1 | Remove the oldest buffered byte |
| rx_byte | output | 8 | Oldest buffered byte |
| buf_level | output | LVL_W | Bytes in the holding buffer |
| stat_clr | input | 2 | Flag clear strobes: bit 0 NACK, bit 1 ARDY |
| stat_nack | output | 1 | Sticky not-acknowledged flag |
| stat_ardy | output | 1 | Sticky access-ready flag |
| stat_rrdy | output | 1 | Receive data available |
| stat_xrdy | output | 1 | Transmit data wanted |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 stop |
| bus_addr | output | 7 | Address latched at start |
| bus_rd | output | 1 | Direction for start: 1 read |
| bus_wdata | output | 8 | Byte for a send |
| bus_done | input | 1 | Operation complete pulse |
| bus_ack | input | 1 | Acknowledge with `bus_done` |
| bus_rdata | input | 8 | Byte returned with `bus_done` |

## Verification
A control write takes effect at the next clock edge, so its effect on the control word, the running count and `bus_req` shows one cycle after the strobe. The bus model raises `bus_done` two cycles after it sees a request. The flags, the buffer level, the count and the next state all update on the edge that samples `bus_done`, and the next request shows one cycle after that. Inputs are driven and outputs are sampled on the falling edge. Each transfer-level result is checked only once the master bit has dropped with no request pending, or after a fixed wait long enough for every operation that can complete. A stimulus is never compared against a value that a register has not yet had a chance to take.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ACTIVE,
        S_SEND,
        S_RECV,
        S_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    localparam int CTRL_W = 16;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'hCF87;

    localparam int B_EN  = 15;
    localparam int B_BE  = 14;
    localparam int B_MST = 10;
    localparam int B_TRX = 9;
    localparam int B_XA  = 8;
    localparam int B_RM  = 2;
    localparam int B_STP = 1;
    localparam int B_STT = 0;

endpackage

// File: rtl/i2cseq_holdbuf.sv
module i2cseq_holdbuf #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [LVL_W-1:0] level_q;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (level_q == LVL_W'(DEPTH));
    assign empty   = (level_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/i2cseq_counter.sv
module i2cseq_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [CNT_W-1:0] prog_data,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] cur,
    output logic             zero
);

    logic [CNT_W-1:0] prog_q;
    logic [CNT_W-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
            cur_q  <= '0;
        end else begin
            if (prog_we) prog_q <= prog_data;
            if (load) begin
                cur_q <= prog_q;
            end else if (dec && (cur_q != '0)) begin
                cur_q <= cur_q - CNT_W'(1);
            end
        end
    end

    assign cur  = cur_q;
    assign zero = (cur_q == '0);

endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
    import i2cseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [1:0]        stat_clr,
    input  logic [6:0]        slave_addr,
    input  logic              buf_empty,
    input  logic              buf_full,
    input  logic              cnt_zero,
    input  logic              bus_done,
    input  logic              bus_ack,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              cnt_load,
    output logic              cnt_dec,
    output logic              buf_pop_bus,
    output logic              buf_push_bus,
    output logic              stat_nack,
    output logic              stat_ardy,
    output logic              stat_xrdy,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [6:0]        bus_addr,
    output logic              bus_rd
);

    seq_state_e        state_q, state_n;
    logic [CTRL_W-1:0] ctrl_n;
    logic [CTRL_W-1:0] wr_val;
    logic [6:0]        addr_q;
    logic              ardy_on_stop_q, ardy_on_stop_n;
    logic              nack_q, ardy_q;
    logic              nack_set, ardy_set;
    logic              abort;

    assign wr_val = ctrl_wdata & CTRL_KEEP;
    assign abort  = ctrl_we && !wr_val[B_EN];

    // next-state and control-word process
    always_comb begin
        state_n        = state_q;
        ctrl_n         = ctrl_q;
        ardy_on_stop_n = ardy_on_stop_q;
        cnt_load       = 1'b0;
        cnt_dec        = 1'b0;
        buf_pop_bus    = 1'b0;
        buf_push_bus   = 1'b0;
        nack_set       = 1'b0;
        ardy_set       = 1'b0;

        if (ctrl_we) begin
            ctrl_n = wr_val;
            if (state_q != S_IDLE) ctrl_n[B_STT] = ctrl_q[B_STT];
        end

        if (abort) begin
            ctrl_n[B_STT] = 1'b0;
            ctrl_n[B_STP] = 1'b0;
            state_n       = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (ctrl_we && wr_val[B_STT]) begin
                        if (wr_val[B_MST]) begin
                            state_n  = S_START;
                            cnt_load = 1'b1;
                        end else begin
                            ctrl_n[B_STT] = 1'b0;
                        end
                    end
                end
                S_START: begin
                    if (bus_done) begin
                        ctrl_n[B_STT] = 1'b0;
                        if (bus_ack) begin
                            state_n = S_ACTIVE;
                        end else begin
                            nack_set       = 1'b1;
                            ctrl_n[B_STP]  = 1'b0;
                            ardy_on_stop_n = 1'b0;
                            state_n        = S_STOP;
                        end
                    end
                end
                S_ACTIVE: begin
                    if (ctrl_n[B_RM]) begin
                        if (ctrl_n[B_STP]) begin
                            ardy_on_stop_n = 1'b0;
                            state_n        = S_STOP;
                        end else if (ctrl_n[B_TRX]) begin
                            if (!buf_empty) state_n = S_SEND;
                        end else if (!buf_full) begin
                            state_n = S_RECV;
                        end
                    end else if (cnt_zero) begin
                        if (ctrl_n[B_STP]) begin
                            ardy_on_stop_n = 1'b1;
                            state_n        = S_STOP;
                        end else begin
                            ardy_set      = 1'b1;
                            ctrl_n[B_MST] = 1'b0;
                            state_n       = S_IDLE;
                        end
                    end else if (ctrl_n[B_TRX]) begin
                        if (!buf_empty) state_n = S_SEND;
                    end else if (!buf_full) begin
                        state_n = S_RECV;
                    end
                end
                S_SEND: begin
                    if (bus_done) begin
                        buf_pop_bus = 1'b1;
                        cnt_dec     = !ctrl_n[B_RM];
                        if (bus_ack) begin
                            state_n = S_ACTIVE;
                        end else begin
                            nack_set       = 1'b1;
                            ctrl_n[B_STP]  = 1'b0;
                            ardy_on_stop_n = 1'b0;
                            state_n        = S_STOP;
                        end
                    end
                end
                S_RECV: begin
                    if (bus_done) begin
                        buf_push_bus = 1'b1;
                        cnt_dec      = !ctrl_n[B_RM];
                        state_n      = S_ACTIVE;
                    end
                end
                S_STOP: begin
                    if (bus_done) begin
                        ctrl_n[B_STP] = 1'b0;
                        ctrl_n[B_MST] = 1'b0;
                        cnt_load      = 1'b1;
                        ardy_set      = ardy_on_stop_q;
                        state_n       = S_IDLE;
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= S_IDLE;
            ctrl_q         <= '0;
            ardy_on_stop_q <= 1'b0;
            addr_q         <= '0;
            nack_q         <= 1'b0;
            ardy_q         <= 1'b0;
        end else begin
            state_q        <= state_n;
            ctrl_q         <= ctrl_n;
            ardy_on_stop_q <= ardy_on_stop_n;
            if (state_q == S_IDLE && state_n == S_START) addr_q <= slave_addr;
            nack_q <= (nack_q && !stat_clr[0]) || nack_set;
            ardy_q <= (ardy_q && !stat_clr[1]) || ardy_set;
        end
    end

    // output process
    always_comb begin
        bus_req = 1'b0;
        bus_op  = OP_START;
        unique case (state_q)
            S_START: begin bus_req = 1'b1; bus_op = OP_START; end
            S_SEND:  begin bus_req = 1'b1; bus_op = OP_SEND;  end
            S_RECV:  begin bus_req = 1'b1; bus_op = OP_RECV;  end
            S_STOP:  begin bus_req = 1'b1; bus_op = OP_STOP;  end
            default: begin bus_req = 1'b0; bus_op = OP_START; end
        endcase
        stat_xrdy = (state_q == S_ACTIVE) && ctrl_q[B_TRX] && buf_empty
                    && (ctrl_q[B_RM] || !cnt_zero);
    end

    assign bus_addr  = addr_q;
    assign bus_rd    = !ctrl_q[B_TRX];
    assign stat_nack = nack_q;
    assign stat_ardy = ardy_q;

endmodule

// File: rtl/i2c_byte_sequencer.sv
module i2c_byte_sequencer
    import i2cseq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [15:0]      ctrl_wdata,
    output logic [15:0]      ctrl_q,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count_cur,
    input  logic [6:0]       slave_addr,
    input  logic             tx_push,
    input  logic [7:0]       tx_byte,
    input  logic             rx_pop,
    output logic [7:0]       rx_byte,
    output logic [LVL_W-1:0] buf_level,
    input  logic [1:0]       stat_clr,
    output logic             stat_nack,
    output logic             stat_ardy,
    output logic             stat_rrdy,
    output logic             stat_xrdy,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic [6:0]       bus_addr,
    output logic             bus_rd,
    output logic [7:0]       bus_wdata,
    input  logic             bus_done,
    input  logic             bus_ack,
    input  logic [7:0]       bus_rdata
);

    logic       cnt_load, cnt_dec, cnt_zero;
    logic       buf_pop_bus, buf_push_bus;
    logic       buf_empty, buf_full;
    logic       buf_push, buf_pop;
    logic [7:0] buf_wdata;
    logic [7:0] buf_head;

    assign buf_push  = buf_push_bus || tx_push;
    assign buf_wdata = buf_push_bus ? bus_rdata : tx_byte;
    assign buf_pop   = buf_pop_bus || rx_pop;

    i2cseq_holdbuf #(.DEPTH(DEPTH), .W(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (buf_push),
        .push_data (buf_wdata),
        .pop       (buf_pop),
        .head      (buf_head),
        .level     (buf_level),
        .empty     (buf_empty),
        .full      (buf_full)
    );

    i2cseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (cnt_we),
        .prog_data (cnt_wdata),
        .load      (cnt_load),
        .dec       (cnt_dec),
        .cur       (count_cur),
        .zero      (cnt_zero)
    );

    i2cseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .stat_clr     (stat_clr),
        .slave_addr   (slave_addr),
        .buf_empty    (buf_empty),
        .buf_full     (buf_full),
        .cnt_zero     (cnt_zero),
        .bus_done     (bus_done),
        .bus_ack      (bus_ack),
        .ctrl_q       (ctrl_q),
        .cnt_load     (cnt_load),
        .cnt_dec      (cnt_dec),
        .buf_pop_bus  (buf_pop_bus),
        .buf_push_bus (buf_push_bus),
        .stat_nack    (stat_nack),
        .stat_ardy    (stat_ardy),
        .stat_xrdy    (stat_xrdy),
        .bus_req      (bus_req),
        .bus_op       (bus_op),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd)
    );

    assign rx_byte   = buf_head;
    assign bus_wdata = buf_head;
    assign stat_rrdy = !ctrl_q[B_TRX] && !buf_empty;

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_we,
    input logic [15:0]      ctrl_wdata,
    input logic [15:0]      ctrl_q,
    input logic             stat_nack,
    input logic             stat_ardy,
    input logic             stat_rrdy,
    input logic             stat_xrdy,
    input logic             bus_req,
    input logic [1:0]       bus_op,
    input logic             bus_done,
    input logic [LVL_W-1:0] buf_level
);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done && !(ctrl_we && !ctrl_wdata[15]))
        |=> (bus_req && $stable(bus_op)));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_wdata[15])
        |=> (!bus_req && ctrl_q[1:0] == 2'b00 && !stat_xrdy));

    p_ardy_mst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ardy) |-> !ctrl_q[10]);

    p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_nack) |-> (bus_req && bus_op == 2'd3));

    p_level_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= LVL_W'(DEPTH));

    p_xrdy_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_xrdy |-> (ctrl_q[9] && buf_level == '0));

    p_rrdy_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rrdy |-> (!ctrl_q[9] && buf_level != '0));

endmodule

bind i2c_byte_sequencer i2cseq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_q     (ctrl_q),
    .stat_nack  (stat_nack),
    .stat_ardy  (stat_ardy),
    .stat_rrdy  (stat_rrdy),
    .stat_xrdy  (stat_xrdy),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_done   (bus_done),
    .buf_level  (buf_level)
);

// File: tb/test_i2c_byte_sequencer.sv
module test_i2c_byte_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int RESP_LAT   = 2;
    localparam logic [6:0] ADDR = 7'h2D;

    // {exp_cnt4, exp_lvl3, exp_nack1, exp_ardy1, exp_stop1, exp_sends3, nack_at3, stp1, pre3, cnt4}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {4'd2, 3'd0, 1'b0, 1'b1, 1'b1, 3'd2, 3'd7, 1'b1, 3'd2, 4'd2},
        {4'd1, 3'd2, 1'b0, 1'b1, 1'b1, 3'd1, 3'd7, 1'b1, 3'd3, 4'd1},
        {4'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd3, 3'd7, 1'b0, 3'd3, 4'd3},
        {4'd4, 3'd2, 1'b1, 1'b0, 1'b1, 3'd2, 3'd2, 1'b1, 3'd4, 4'd4},
        {4'd0, 3'd1, 1'b0, 1'b1, 1'b1, 3'd0, 3'd7, 1'b1, 3'd1, 4'd0},
        {4'd2, 3'd2, 1'b1, 1'b0, 1'b1, 3'd0, 3'd0, 1'b1, 3'd2, 4'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_we = 1'b0;
    logic [15:0]      ctrl_wdata = '0;
    logic [15:0]      ctrl_q;
    logic             cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic [CNT_W-1:0] count_cur;
    logic [6:0]       slave_addr = ADDR;
    logic             tx_push = 1'b0;
    logic [7:0]       tx_byte = '0;
    logic             rx_pop = 1'b0;
    logic [7:0]       rx_byte;
    logic [2:0]       buf_level;
    logic [1:0]       stat_clr = '0;
    logic             stat_nack, stat_ardy, stat_rrdy, stat_xrdy;
    logic             bus_req;
    logic [1:0]       bus_op;
    logic [6:0]       bus_addr;
    logic             bus_rd;
    logic [7:0]       bus_wdata;
    logic             bus_done = 1'b0;
    logic             bus_ack = 1'b0;
    logic [7:0]       bus_rdata = '0;

    int checks = 0;
    int errors = 0;

    int         n_ops = 0;
    logic [1:0] op_log   [32];
    logic [7:0] data_log [32];
    logic       rd_log   [32];
    logic [6:0] addr_log [32];
    int         nack_at  = 7;
    int         send_idx = 0;
    int         recv_idx = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_byte_sequencer #(.DEPTH(4), .CNT_W(CNT_W)) i_i2c_byte_sequencer (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .count_cur(count_cur),
        .slave_addr(slave_addr),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
        .buf_level(buf_level), .stat_clr(stat_clr),
        .stat_nack(stat_nack), .stat_ardy(stat_ardy),
        .stat_rrdy(stat_rrdy), .stat_xrdy(stat_xrdy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    // bus responder model
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && rst_n) begin
                repeat (RESP_LAT) @(negedge clk);
                if (bus_req) begin
                    if (n_ops < 32) begin
                        op_log[n_ops]   = bus_op;
                        data_log[n_ops] = bus_wdata;
                        rd_log[n_ops]   = bus_rd;
                        addr_log[n_ops] = bus_addr;
                    end
                    n_ops = n_ops + 1;
                    bus_ack   = 1'b1;
                    bus_rdata = 8'h00;
                    case (bus_op)
                        2'd0: bus_ack = (nack_at != 0);
                        2'd1: begin
                            send_idx = send_idx + 1;
                            bus_ack  = (send_idx != nack_at);
                        end
                        2'd2: begin
                            bus_rdata = 8'hA0 + 8'(recv_idx);
                            recv_idx  = recv_idx + 1;
                        end
                        default: bus_ack = 1'b1;
                    endcase
                    bus_done = 1'b1;
                    @(negedge clk);
                    bus_done = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl_we = 1'b0; cnt_we = 1'b0; tx_push = 1'b0; rx_pop = 1'b0; stat_clr = '0;
        repeat (3) @(negedge clk);
        n_ops = 0; send_idx = 0; recv_idx = 0; nack_at = 7;
        rst_n = 1'b1;
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_cnt(input int v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = CNT_W'(v);
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); tx_push = 1'b1; tx_byte = b;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!ctrl_q[10] && !bus_req) break;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic int count_op(input logic [1:0] op);
        int n = 0;
        for (int i = 0; i < n_ops && i < 32; i++) if (op_log[i] == op) n++;
        return n;
    endfunction

    initial begin
        int sends, first_send;
        // reset state (R1)
        do_reset();
        @(negedge clk);
        chk(ctrl_q == 16'h0 && count_cur == 0 && buf_level == 0, "R1 reset", ctrl_q, 0);
        chk(!stat_nack && !stat_ardy && !stat_rrdy && !stat_xrdy && !bus_req,
            "R1 reset flags", {stat_nack, stat_ardy, stat_rrdy, stat_xrdy, bus_req}, 0);

        // vector table: normal-mode transmit runs
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            e = VEC[v];
            do_reset();
            wr_cnt(int'(e[3:0]));
            for (int k = 0; k < int'(e[6:4]); k++) push(8'(16 * v + k));
            nack_at = int'(e[10:8]);
            wr_ctrl(16'h8601 | (16'(e[7]) << 1));
            wait_idle();
            sends = count_op(2'd1);
            chk(sends == int'(e[13:11]), "R4 send count", sends, e[13:11]);
            chk(count_op(2'd3) == int'(e[14]), "R5 stop count", count_op(2'd3), e[14]);
            chk(stat_ardy == e[15], "R5 ardy", stat_ardy, e[15]);
            chk(stat_nack == e[16], "R7 nack", stat_nack, e[16]);
            chk(buf_level == e[19:17], "R11 level", buf_level, e[19:17]);
            chk(count_cur == CNT_W'(e[23:20]), "R3 count", count_cur, e[23:20]);
            chk(ctrl_q[1:0] == 2'b00 && !ctrl_q[10], "R2 stt stp mst clear", ctrl_q, 0);
            chk(op_log[0] == 2'd0 && rd_log[0] == 1'b0 && addr_log[0] == ADDR,
                "R2 start op", {op_log[0], rd_log[0], addr_log[0]}, {2'd0, 1'b0, ADDR});
            first_send = 1;
            for (int k = 0; k < sends; k++)
                chk(data_log[first_send + k] == 8'(16 * v + k), "R4 send order",
                    data_log[first_send + k], 16 * v + k);
        end

        // control mask and abort on a disabled write (R1, R9)
        do_reset();
        wr_ctrl(16'h7FFF);
        @(negedge clk);
        chk(ctrl_q == 16'h4F84, "R1 mask", ctrl_q, 16'h4F84);
        chk(!bus_req && n_ops == 0, "R9 no op when disabled", n_ops, 0);

        // start with master 0 is ignored (R2)
        do_reset();
        wr_ctrl(16'h8001);
        repeat (10) @(negedge clk);
        chk(n_ops == 0 && !bus_req, "R2 start without master", n_ops, 0);
        chk(ctrl_q == 16'h8000, "R2 stt cleared", ctrl_q, 16'h8000);

        // normal receive, buffer-full wait (R6)
        do_reset();
        wr_cnt(6);
        wr_ctrl(16'h8403);
        repeat (40) @(negedge clk);
        chk(buf_level == 3'd4, "R6 fills to four", buf_level, 4);
        chk(count_cur == 16'd2, "R6 count after four", count_cur, 2);
        chk(stat_rrdy && ctrl_q[10], "R6 rrdy waiting", {stat_rrdy, ctrl_q[10]}, 3);
        chk(rd_log[0] == 1'b1, "R2 read direction", rd_log[0], 1);
        for (int k = 0; k < 6; k++) begin
            chk(rx_byte == 8'hA0 + 8'(k), "R6 receive order", rx_byte, 8'hA0 + k);
            pop();
            repeat (12) @(negedge clk);
        end
        chk(count_op(2'd2) == 6 && count_op(2'd3) == 1, "R6 recv ops", count_op(2'd2), 6);
        chk(stat_ardy && count_cur == 16'd6, "R3 reload after stop", count_cur, 6);
        chk(!stat_rrdy && buf_level == 0, "R6 rrdy drops", stat_rrdy, 0);

        // transmit waits with xrdy, then W1C of flags (R4, R10)
        do_reset();
        wr_cnt(3);
        push(8'h55);
        wr_ctrl(16'h8603);
        repeat (30) @(negedge clk);
        chk(count_op(2'd1) == 1 && stat_xrdy, "R4 xrdy wait", count_op(2'd1), 1);
        chk(count_cur == 16'd2 && ctrl_q[10], "R4 count decrement", count_cur, 2);
        push(8'h66);
        push(8'h77);
        wait_idle();
        chk(count_op(2'd1) == 3 && data_log[3] == 8'h77, "R4 resumed", data_log[3], 8'h77);
        chk(stat_ardy && !stat_xrdy, "R5 done", stat_ardy, 1);
        @(negedge clk); stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00;
        chk(stat_ardy, "R10 ardy kept", stat_ardy, 1);
        @(negedge clk); stat_clr = 2'b10;
        @(negedge clk); stat_clr = 2'b00;
        chk(!stat_ardy, "R10 ardy cleared", stat_ardy, 0);

        // repeat mode: count ignored, ends on stop (R8)
        do_reset();
        wr_cnt(1);
        push(8'h31); push(8'h32); push(8'h33);
        wr_ctrl(16'h8605);
        repeat (30) @(negedge clk);
        chk(count_op(2'd1) == 3 && stat_xrdy, "R8 repeat sends", count_op(2'd1), 3);
        chk(count_cur == 16'd1 && ctrl_q[10], "R8 count untouched", count_cur, 1);
        wr_ctrl(16'h8606);
        wait_idle();
        chk(op_log[n_ops - 1] == 2'd3 && ctrl_q[1] == 1'b0, "R8 stop", op_log[n_ops - 1], 3);
        chk(!stat_ardy && !ctrl_q[10], "R8 no ardy", stat_ardy, 0);

        // abort while waiting (R9)
        do_reset();
        wr_cnt(3);
        wr_ctrl(16'h8603);
        repeat (20) @(negedge clk);
        chk(stat_xrdy, "R9 pre-abort wait", stat_xrdy, 1);
        wr_ctrl(16'h0603);
        chk(ctrl_q == 16'h0600 && !stat_xrdy, "R9 abort clears", ctrl_q, 16'h0600);
        push(8'h99);
        repeat (20) @(negedge clk);
        chk(n_ops == 1 && !bus_req, "R9 idle after abort", n_ops, 1);

        // buffer overflow and underflow (R11)
        do_reset();
        for (int k = 0; k < 5; k++) push(8'hC0 + 8'(k));
        chk(buf_level == 3'd4 && rx_byte == 8'hC0, "R11 full ignore", buf_level, 4);
        chk(stat_rrdy, "R6 rrdy while idle", stat_rrdy, 1);
        for (int k = 0; k < 5; k++) pop();
        chk(buf_level == 3'd0, "R11 empty ignore", buf_level, 0);
        push(8'hE1);
        chk(rx_byte == 8'hE1 && buf_level == 3'd1, "R11 after underflow", rx_byte, 8'hE1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule